// File: doc/BRIEF.md
# Prescaled PWM Output Channel

This block produces one pulse-width-modulated output from three programmed values: a clock divider, a period length and a compare threshold. A divider stage turns its clock source into a step strobe. A period counter advances on each step and runs through the values 1 up to the period length before it wraps. The output is active while the counter value is at or below the threshold. The clock source is either the main clock or an external low-frequency tick-enable input, so a slow always-on time base can keep the waveform alive while the main clock rate is reduced.

Software programs the channel through a write-only register port. It stops the channel, loads the divider, period and threshold, and starts the channel again. Threshold and period may also be rewritten while the channel runs. Those writes wait in holding registers until the current period ends, so no period is ever cut short or stretched. An invert bit serves active-low loads. A drive-mode bit chooses between a push-pull pad pair and an open-drain pad pair.

Top module: `pwm_chan_top`

## Requirements
- R1: A divider value N makes the period counter advance once every N+1 steps of the selected clock source.
- R2: The period counter takes the values 1 up to the period length and then returns to 1. The output is active while the counter is less than or equal to the threshold, so one period lasts period*(N+1) source steps.
- R3: A threshold equal to the period length keeps the output active for the whole period.
- R4: A threshold greater than the period length, or a threshold of zero, keeps the output inactive for the whole period.
- R5: With the invert bit set, the active level is 0 and the inactive level is 1. The same threshold gives the same active time.
- R6: While the enable bit is clear, the output holds its inactive level, honouring the invert bit, from the first cycle after the disabling write. The divider and the counter are cleared, so a restart begins a fresh period.
- R7: A write to the divider register while the channel is enabled is ignored, and the channel keeps its old step rate.
- R8: A write to the threshold or period register while the channel is enabled takes effect at the start of the next period. The current period completes with the old values.
- R9: With the slow-source bit set, the divider counts only cycles in which slow_tick_i is 1.
- R10: In push-pull mode pad_oe_o is 1 and pad_do_o follows pwm_o. In open-drain mode pad_do_o is 0 and pad_oe_o is 1 exactly when pwm_o is 0.
- R11: A write happens at a rising clock edge with cfg_we_i high. The address cfg_sel_i selects the register: 0 is control (bit0 enable, bit1 invert, bit2 slow source, bit3 open drain), 1 is the divider, 2 is the period length and 3 is the threshold.
- R12: After reset all registers are zero. The outputs are then pwm_o=0, pad_oe_o=1 and pad_do_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst | input | 1 | Synchronous reset, active high |
| slow_tick_i | input | 1 | Low-frequency tick enable, used when the slow-source bit is set |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_sel_i | input | 2 | Register address |
| cfg_wdata_i | input | DATA_W (16) | Register write data |
| pwm_o | output | 1 | PWM waveform after polarity |
| pad_oe_o | output | 1 | Pad output enable |
| pad_do_o | output | 1 | Pad output data |

## Verification
A table of settings covers several points that an off-by-one would break. With threshold equal to the period, a design that compares with "less than" loses one step of every period. With threshold one above the period, a design that does not clamp shows a full-duty output. With a threshold of zero and a period of one, a design that starts counting at zero glitches active once per period. The bench also counts rising edges over a fixed window. This catches a divider write that leaks in while the channel runs, and a slow-source bit that is ignored, because either fault changes the number of periods seen. A threshold is rewritten one cycle into a period: a design without holding registers shows the new active time one period too early. Finally, the bench checks that the output drops on the cycle after disable, and that the open-drain pair drives only low.

// File: rtl/pwm_chan_pkg.sv
package pwm_chan_pkg;

    localparam int SEL_W = 2;

    typedef enum logic [SEL_W-1:0] {
        REG_CTRL   = 2'd0,
        REG_DIV    = 2'd1,
        REG_PERIOD = 2'd2,
        REG_THRESH = 2'd3
    } reg_sel_e;

    // Control word: bit0 enable, bit1 invert, bit2 slow source, bit3 open drain
    typedef struct packed {
        logic open_drain;
        logic slow_src;
        logic invert;
        logic enable;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    typedef enum logic {
        DRIVE_PUSH_PULL = 1'b0,
        DRIVE_OPEN_DRAIN = 1'b1
    } drive_e;

endpackage

// File: rtl/pwm_cfg_regs.sv
module pwm_cfg_regs
    import pwm_chan_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DIV_W  = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we_i,
    input  logic [SEL_W-1:0]  sel_i,
    input  logic [DATA_W-1:0] wdata_i,
    output ctrl_t             ctrl_o,
    output logic [DIV_W-1:0]  div_o,
    output logic [CNT_W-1:0]  period_sh_o,
    output logic [CNT_W-1:0]  thresh_sh_o
);

    ctrl_t             ctrl_q;
    logic [DIV_W-1:0]  div_q;
    logic [CNT_W-1:0]  period_q;
    logic [CNT_W-1:0]  thresh_q;
    reg_sel_e          sel;

    assign sel = reg_sel_e'(sel_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            div_q    <= '0;
            period_q <= '0;
            thresh_q <= '0;
        end else if (we_i) begin
            case (sel)
                REG_CTRL:   ctrl_q   <= ctrl_t'(wdata_i[CTRL_W-1:0]);
                REG_DIV:    if (!ctrl_q.enable) div_q <= wdata_i[DIV_W-1:0];
                REG_PERIOD: period_q <= wdata_i[CNT_W-1:0];
                REG_THRESH: thresh_q <= wdata_i[CNT_W-1:0];
                default:    ;
            endcase
        end
    end

    assign ctrl_o      = ctrl_q;
    assign div_o       = div_q;
    assign period_sh_o = period_q;
    assign thresh_sh_o = thresh_q;

    // R7: divider is frozen while the channel runs
    p_div_locked_r7: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.enable |=> $stable(div_q));

endmodule

// File: rtl/pwm_divider.sv
module pwm_divider #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_i,
    input  logic             slow_sel_i,
    input  logic             slow_tick_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             step_o
);

    logic [DIV_W-1:0] div_cnt_q;
    logic             src_tick;
    logic             at_limit;

    assign src_tick = slow_sel_i ? slow_tick_i : 1'b1;
    assign at_limit = (div_cnt_q == div_i);
    assign step_o   = en_i && src_tick && at_limit;

    always_ff @(posedge clk) begin
        if (rst || !en_i) begin
            div_cnt_q <= '0;
        end else if (src_tick) begin
            div_cnt_q <= at_limit ? '0 : div_cnt_q + 1'b1;
        end
    end

    // R9: without a source tick the divider does not move
    p_slow_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (en_i && !src_tick) |=> (!en_i || $stable(div_cnt_q)));

endmodule

// File: rtl/pwm_period_cnt.sv
module pwm_period_cnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_i,
    input  logic             step_i,
    input  logic [CNT_W-1:0] period_sh_i,
    input  logic [CNT_W-1:0] thresh_sh_i,
    output logic             active_o
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] period_act_q;
    logic [CNT_W-1:0] thresh_act_q;
    logic             wrap;

    assign wrap = (cnt_q == '0) || (cnt_q >= period_act_q);

    always_ff @(posedge clk) begin
        if (rst || !en_i) begin
            cnt_q <= '0;
        end else if (step_i) begin
            cnt_q <= wrap ? CNT_W'(1) : cnt_q + 1'b1;
        end
    end

    // Holding registers are copied only when a new period begins
    always_ff @(posedge clk) begin
        if (rst) begin
            period_act_q <= '0;
            thresh_act_q <= '0;
        end else if (en_i && step_i && wrap) begin
            period_act_q <= period_sh_i;
            thresh_act_q <= thresh_sh_i;
        end
    end

    assign active_o = (cnt_q != '0)
                   && (thresh_act_q <= period_act_q)
                   && (cnt_q <= thresh_act_q);

    // R1: counter only moves on a divider step
    p_cnt_hold_r1: assert property (@(posedge clk) disable iff (rst)
        (en_i && !step_i) |=> (!en_i || $stable(cnt_q)));

    // R2: counter stays inside 1..period
    p_cnt_range_r2: assert property (@(posedge clk) disable iff (rst)
        (cnt_q != '0 && period_act_q != '0) |-> (cnt_q <= period_act_q));

    // R6: disabled channel clears its counter
    p_idle_clear_r6: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> (cnt_q == '0));

    // R8: live threshold changes only on the first count of a period
    p_thresh_boundary_r8: assert property (@(posedge clk) disable iff (rst)
        !$stable(thresh_act_q) |-> (cnt_q == CNT_W'(1)));

endmodule

// File: rtl/pwm_chan_top.sv
module pwm_chan_top
    import pwm_chan_pkg::*;
#(
    parameter  int CNT_W  = 16,
    parameter  int DIV_W  = 16,
    localparam int DATA_W = (CNT_W > DIV_W) ? CNT_W : DIV_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              slow_tick_i,
    input  logic              cfg_we_i,
    input  logic [1:0]        cfg_sel_i,
    input  logic [DATA_W-1:0] cfg_wdata_i,
    output logic              pwm_o,
    output logic              pad_oe_o,
    output logic              pad_do_o
);

    ctrl_t            ctrl;
    logic [DIV_W-1:0] div_val;
    logic [CNT_W-1:0] period_sh;
    logic [CNT_W-1:0] thresh_sh;
    logic             step;
    logic             active;
    logic             level;
    drive_e           drive;

    pwm_cfg_regs #(
        .CNT_W  (CNT_W),
        .DIV_W  (DIV_W),
        .DATA_W (DATA_W)
    ) u_regs (
        .clk         (clk),
        .rst         (rst),
        .we_i        (cfg_we_i),
        .sel_i       (cfg_sel_i),
        .wdata_i     (cfg_wdata_i),
        .ctrl_o      (ctrl),
        .div_o       (div_val),
        .period_sh_o (period_sh),
        .thresh_sh_o (thresh_sh)
    );

    pwm_divider #(
        .DIV_W (DIV_W)
    ) u_div (
        .clk         (clk),
        .rst         (rst),
        .en_i        (ctrl.enable),
        .slow_sel_i  (ctrl.slow_src),
        .slow_tick_i (slow_tick_i),
        .div_i       (div_val),
        .step_o      (step)
    );

    pwm_period_cnt #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk         (clk),
        .rst         (rst),
        .en_i        (ctrl.enable),
        .step_i      (step),
        .period_sh_i (period_sh),
        .thresh_sh_i (thresh_sh),
        .active_o    (active)
    );

    assign level = (active && ctrl.enable) ^ ctrl.invert;
    assign drive = drive_e'(ctrl.open_drain);
    assign pwm_o = level;

    always_comb begin
        case (drive)
            DRIVE_OPEN_DRAIN: begin
                pad_oe_o = !level;
                pad_do_o = 1'b0;
            end
            default: begin
                pad_oe_o = 1'b1;
                pad_do_o = level;
            end
        endcase
    end

    // R6: a stopped channel sits at its inactive level
    p_off_level_r6: assert property (@(posedge clk) disable iff (rst)
        !ctrl.enable |-> (pwm_o == ctrl.invert));

    // R10: open-drain pair never drives high
    p_od_pair_r10: assert property (@(posedge clk) disable iff (rst)
        ctrl.open_drain |-> (!pad_do_o && (pad_oe_o == !pwm_o)));

    // R10: push-pull pair always drives
    p_pp_pair_r10: assert property (@(posedge clk) disable iff (rst)
        !ctrl.open_drain |-> (pad_oe_o && (pad_do_o == pwm_o)));

endmodule

// File: tb/pwm_chan_top_tb.sv
module pwm_chan_top_tb;

    localparam int CLK_PERIOD = 10;

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_DIV  = 2'd1;
    localparam logic [1:0] A_PER  = 2'd2;
    localparam logic [1:0] A_THR  = 2'd3;

    typedef struct packed {
        logic [15:0] div;
        logic [15:0] per;
        logic [15:0] thr;
        logic        inv;
        logic [15:0] act;   // active clocks per period
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{16'd0, 16'd10, 16'd3,  1'b0, 16'd3},
        '{16'd0, 16'd10, 16'd10, 1'b0, 16'd10},
        '{16'd0, 16'd10, 16'd11, 1'b0, 16'd0},
        '{16'd2, 16'd8,  16'd5,  1'b0, 16'd15},
        '{16'd1, 16'd6,  16'd0,  1'b0, 16'd0},
        '{16'd3, 16'd5,  16'd2,  1'b1, 16'd8},
        '{16'd0, 16'd1,  16'd1,  1'b0, 16'd1},
        '{16'd4, 16'd4,  16'd4,  1'b1, 16'd20}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        slow_tick_i = 1'b0;
    logic        cfg_we_i = 1'b0;
    logic [1:0]  cfg_sel_i = '0;
    logic [15:0] cfg_wdata_i = '0;
    logic        pwm_o;
    logic        pad_oe_o;
    logic        pad_do_o;

    int checks = 0;
    int errors = 0;
    int slow_div = 0;

    pwm_chan_top u_dut (
        .clk         (clk),
        .rst         (rst),
        .slow_tick_i (slow_tick_i),
        .cfg_we_i    (cfg_we_i),
        .cfg_sel_i   (cfg_sel_i),
        .cfg_wdata_i (cfg_wdata_i),
        .pwm_o       (pwm_o),
        .pad_oe_o    (pad_oe_o),
        .pad_do_o    (pad_do_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // slow source: one tick every third clock
    always @(negedge clk) begin
        slow_div    <= (slow_div == 2) ? 0 : slow_div + 1;
        slow_tick_i <= (slow_div == 2);
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // R11: one register write, returns at the negedge after the write edge
    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        cfg_we_i    = 1'b1;
        cfg_sel_i   = a;
        cfg_wdata_i = d;
        @(negedge clk);
        cfg_we_i = 1'b0;
    endtask

    task automatic measure(input int n, output int highs, output int rises);
        logic prev;
        prev  = pwm_o;
        highs = 0;
        rises = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (pwm_o) highs++;
            if (pwm_o && !prev) rises++;
            prev = pwm_o;
        end
    endtask

    function automatic string vreq(input int i);
        case (i)
            0: vreq = "R2 R11 vec0";
            1: vreq = "R3 vec1";
            2: vreq = "R4 vec2";
            3: vreq = "R1 vec3";
            4: vreq = "R4 vec4";
            5: vreq = "R5 vec5";
            6: vreq = "R3 vec6";
            default: vreq = "R5 vec7";
        endcase
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int h, r, bad, wait_n;
        logic prev;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12: reset state
        check("R12 pwm_o", pwm_o, 0);
        check("R12 pad_oe_o", pad_oe_o, 1);
        check("R12 pad_do_o", pad_do_o, 0);

        // table walk
        for (int i = 0; i < NVEC; i++) begin
            wr(A_CTRL, 16'h0);
            wr(A_DIV, VECS[i].div);
            wr(A_PER, VECS[i].per);
            wr(A_THR, VECS[i].thr);
            wr(A_CTRL, {14'd0, VECS[i].inv, 1'b1});
            repeat (2 * (int'(VECS[i].div) + 1) + 2) @(negedge clk);
            measure(2 * int'(VECS[i].per) * (int'(VECS[i].div) + 1), h, r);
            if (VECS[i].inv)
                h = 2 * int'(VECS[i].per) * (int'(VECS[i].div) + 1) - h;
            check(vreq(i), h, 2 * int'(VECS[i].act));
        end

        // R6: disabled with invert set holds level 1
        wr(A_CTRL, 16'h2);
        measure(6, h, r);
        check("R6 disabled inverted level", h, 6);

        // R6: disable mid-run drops output on the next cycle
        wr(A_CTRL, 16'h0);
        wr(A_DIV, 16'd0);
        wr(A_PER, 16'd4);
        wr(A_THR, 16'd4);
        wr(A_CTRL, 16'h1);
        repeat (4) @(negedge clk);
        check("R6 running before disable", pwm_o, 1);
        wr(A_CTRL, 16'h0);
        check("R6 output after disable", pwm_o, 0);

        // R7: divider write while running ignored (rise count per window)
        wr(A_THR, 16'd1);
        wr(A_CTRL, 16'h1);
        repeat (4) @(negedge clk);
        wr(A_DIV, 16'd3);
        repeat (4) @(negedge clk);
        measure(16, h, r);
        check("R7 periods in 16 clocks", r, 4);
        check("R7 high clocks", h, 4);

        // R9: slow source, threshold 2 of 4, tick every third clock
        wr(A_CTRL, 16'h0);
        wr(A_THR, 16'd2);
        wr(A_CTRL, 16'h5);
        repeat (30) @(negedge clk);
        measure(24, h, r);
        check("R9 periods in 24 clocks", r, 2);
        check("R9 high clocks", h, 12);

        // R10: open-drain pair
        wr(A_CTRL, 16'h9);
        repeat (4) @(negedge clk);
        bad = 0;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            if (pad_do_o || (pad_oe_o != !pwm_o)) bad++;
        end
        check("R10 open-drain mismatches", bad, 0);
        // R10: push-pull pair
        wr(A_CTRL, 16'h1);
        bad = 0;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            if (!pad_oe_o || (pad_do_o != pwm_o)) bad++;
        end
        check("R10 push-pull mismatches", bad, 0);

        // R8: threshold rewrite one cycle into a period
        wr(A_CTRL, 16'h0);
        wr(A_PER, 16'd10);
        wr(A_THR, 16'd3);
        wr(A_CTRL, 16'h1);
        prev = pwm_o;
        wait_n = 0;
        forever begin
            @(negedge clk);
            wait_n++;
            if ((pwm_o && !prev) || wait_n > 40) break;
            prev = pwm_o;
        end
        // at this negedge the counter is 1; write lands as it moves to 2
        cfg_we_i    = 1'b1;
        cfg_sel_i   = A_THR;
        cfg_wdata_i = 16'd7;
        h = 1;
        @(negedge clk);
        cfg_we_i = 1'b0;
        if (pwm_o) h++;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            if (pwm_o) h++;
        end
        check("R8 current period keeps old threshold", h, 3);
        measure(10, h, r);
        check("R8 next period uses new threshold", h, 7);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule